// File: doc/BRIEF.md
# NAND Read Prefetch FIFO Engine

This block pulls a programmed number of bytes from a NAND data port into an internal byte FIFO without any software loop. Software sets a configuration word, a byte count, and then writes a start command. While the transfer runs, the engine requests bytes over a simple request/acknowledge handshake. It stops requesting whenever the FIFO is nearly full. The host reads the buffered bytes out as 32-bit words from a fixed data address. A status word reports the bytes still to fetch and the bytes currently buffered.

The engine only reads. Command and address cycles on the flash, error correction and write posting are handled elsewhere. The host sees five word addresses: configuration (0), byte count (1), control (2), status (3) and data (4).

Top module: `prf_engine`

## Requirements
- R1: After reset the configuration, control and status words read 0, `nand_req` is low and `thr_hit` is low.
- R2: The configuration word has direction in bit 0 (0 = read prefetch), enable in bit 7, FIFO threshold in bits 14:8 and chip select in bits 26:24. Chip select drives `nand_cs`. A write whose threshold is above 64 is ignored entirely. A threshold of 64 or less is stored, even while a transfer is active.
- R3: Writing control with bit 0 = 1 starts a transfer only when the engine is idle, enable is 1 and direction is 0. Starting loads the remaining count from the byte count register. While busy, a start is refused and leaves the remaining count unchanged. Control reads back busy in bit 0.
- R4: `nand_req` is high only while busy, with a nonzero remaining count and at least 4 free FIFO bytes. Each cycle with `nand_req` and `nand_ack` both high takes one byte from `nand_byte` and decrements the remaining count.
- R5: With a 64-byte FIFO and a continuously acknowledging flash, fetching pauses at a fill of 61 bytes.
- R6: Reading the data address with 4 or more bytes buffered returns the oldest byte in bits 7:0 and the next three bytes in ascending lanes, and removes those 4 bytes.
- R7: A byte arriving in the same cycle as a word read is kept, so both the data and the fill level remain exact.
- R8: Status holds the remaining count in bits 13:0, the FIFO fill in bits 30:24 and the underflow flag in bit 31.
- R9: Reading data with fewer than 4 bytes buffered returns the last word that was removed and sets the underflow flag. The flag stays set until a start is accepted.
- R10: Busy clears by itself once the remaining count is 0 and the FIFO is empty.
- R11: Writing control with bit 0 = 0 clears busy, the remaining count, the FIFO and the configuration word.
- R12: `thr_hit` is high while busy and the fill is at least the programmed threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (a read of the data address removes a word) |
| host_addr | input | 3 | Word address: 0 config, 1 count, 2 control, 3 status, 4 data |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the address in the same cycle |
| nand_req | output | 1 | Byte request to the flash port |
| nand_ack | input | 1 | Byte valid from the flash port |
| nand_byte | input | 8 | Byte from the flash port |
| nand_cs | output | 3 | Chip select taken from the configuration word |
| thr_hit | output | 1 | Fill has reached the threshold |

## Verification
The tricky overlap is a flash byte arriving in the same cycle that the host removes a word. The FIFO must then add one byte and subtract four in a single update. This overlap happens naturally in the table-driven streams: with a continuously acknowledging flash, the host polls status and reads data while bytes keep arriving. The result is judged by the exact value of every word read, in order, and by the engine returning to idle with the right remaining count and fill once the last word has been read.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Host-visible word addresses
    typedef enum logic [2:0] {
        ADR_CFG  = 3'd0,
        ADR_CNT  = 3'd1,
        ADR_CTRL = 3'd2,
        ADR_STAT = 3'd3,
        ADR_DATA = 3'd4
    } prf_addr_e;

    // Configuration word layout (fixed, bits 31..0)
    typedef struct packed {
        logic [4:0] rsv_hi;
        logic [2:0] csel;
        logic [8:0] rsv_mid;
        logic [6:0] thr;
        logic       en;
        logic [5:0] rsv_lo;
        logic       dir;
    } prf_cfg_t;

endpackage

// File: rtl/prf_fifo.sv
module prf_fifo #(
    parameter int DEPTH = 64,
    parameter int WB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            push_i,
    input  logic [7:0]      byte_i,
    input  logic            pop_i,
    output logic [8*WB-1:0] word_o,
    output logic [FW-1:0]   fill_o
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [FW-1:0]         fill;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            s_d.wp   = '0;
            s_d.rp   = '0;
            s_d.fill = '0;
        end else begin
            if (push_i) begin
                s_d.mem[s_q.wp] = byte_i;
                s_d.wp          = s_q.wp + AW'(1);
            end
            if (pop_i) begin
                s_d.rp = s_q.rp + AW'(WB);
            end
            s_d.fill = s_q.fill + FW'(push_i) - (pop_i ? FW'(WB) : FW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Oldest byte lands in the lowest lane
    for (genvar b = 0; b < WB; b++) begin : g_lane
        assign word_o[8*b +: 8] = s_q.mem[s_q.rp + AW'(b)];
    end

    assign fill_o = s_q.fill;

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= FW'(DEPTH)) else $error("fill above depth"); // R5

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (s_q.fill <= FW'(DEPTH - WB))) else $error("push into tight fifo"); // R4

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (s_q.fill >= FW'(WB))) else $error("pop without a word"); // R6

    AST_PUSH_POP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i) |=> (s_q.fill == $past(s_q.fill) + FW'(1) - FW'(WB)))
        else $error("overlap lost a byte"); // R7

endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
    import prf_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int THR_MAX = 64,
    parameter int WB      = 4,
    parameter int FW      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg_i,
    input  logic             wr_cnt_i,
    input  logic             wr_ctrl_i,
    input  logic             rd_data_i,
    input  logic [31:0]      wdata_i,
    input  logic             push_i,
    input  logic [FW-1:0]    fill_i,
    input  logic [8*WB-1:0]  word_i,
    output prf_cfg_t         cfg_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rem_o,
    output logic             busy_o,
    output logic             udf_o,
    output logic [8*WB-1:0]  last_o,
    output logic             pop_o,
    output logic             flush_o
);

    typedef struct packed {
        prf_cfg_t         cfg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rem;
        logic             busy;
        logic             udf;
        logic [8*WB-1:0]  last;
    } ctrl_st_t;

    ctrl_st_t s_d, s_q;
    logic     start_acc, stop_req, pop;

    always_comb begin
        s_d       = s_q;
        start_acc = wr_ctrl_i && wdata_i[0] && !s_q.busy && s_q.cfg.en && !s_q.cfg.dir;
        stop_req  = wr_ctrl_i && !wdata_i[0];
        pop       = rd_data_i && (fill_i >= FW'(WB));

        if (wr_cfg_i && (wdata_i[14:8] <= 7'(THR_MAX))) s_d.cfg = prf_cfg_t'(wdata_i);
        if (wr_cnt_i) s_d.cnt = wdata_i[CNT_W-1:0];
        if (push_i && (s_q.rem != '0)) s_d.rem = s_q.rem - CNT_W'(1);
        if (pop) s_d.last = word_i;
        if (rd_data_i && !pop) s_d.udf = 1'b1;
        if (s_q.busy && (s_q.rem == '0) && (fill_i == '0)) s_d.busy = 1'b0;

        if (start_acc) begin
            s_d.busy = 1'b1;
            s_d.rem  = s_q.cnt;
            s_d.udf  = 1'b0;
        end
        if (stop_req) begin
            s_d.busy = 1'b0;
            s_d.rem  = '0;
            s_d.cfg  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o   = s_q.cfg;
    assign cnt_o   = s_q.cnt;
    assign rem_o   = s_q.rem;
    assign busy_o  = s_q.busy;
    assign udf_o   = s_q.udf;
    assign last_o  = s_q.last;
    assign pop_o   = pop;
    assign flush_o = start_acc || stop_req;

    AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (s_q.rem != '0) && wr_ctrl_i && wdata_i[0] && !push_i)
        |=> (s_q.busy && (s_q.rem == $past(s_q.rem)))) else $error("start taken while busy"); // R3

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !wdata_i[0]) |=> (!s_q.busy && (s_q.cfg == '0) && (s_q.rem == '0)))
        else $error("stop left state"); // R11

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.udf && !(wr_ctrl_i && wdata_i[0])) |=> s_q.udf) else $error("underflow flag dropped"); // R9

    AST_THR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg.thr <= 7'(THR_MAX)) else $error("threshold above limit"); // R2

endmodule

// File: rtl/prf_engine.sv
module prf_engine
    import prf_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 14,
    localparam int WB        = 4,
    localparam int FW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        nand_req,
    input  logic        nand_ack,
    input  logic [7:0]  nand_byte,
    output logic [2:0]  nand_cs,
    output logic        thr_hit
);

    prf_cfg_t         cfg;
    logic [CNT_W-1:0] cnt, rem;
    logic             busy, udf, pop, flush, push;
    logic [8*WB-1:0]  head_word, last_word;
    logic [FW-1:0]    fill;
    logic [31:0]      stat_word;

    logic wr_cfg, wr_cnt, wr_ctrl, rd_data;
    assign wr_cfg  = host_wr && (host_addr == ADR_CFG);
    assign wr_cnt  = host_wr && (host_addr == ADR_CNT);
    assign wr_ctrl = host_wr && (host_addr == ADR_CTRL);
    assign rd_data = host_rd && (host_addr == ADR_DATA);

    prf_ctrl #(
        .CNT_W   (CNT_W),
        .THR_MAX (FIFO_DEPTH),
        .WB      (WB),
        .FW      (FW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cfg_i  (wr_cfg),
        .wr_cnt_i  (wr_cnt),
        .wr_ctrl_i (wr_ctrl),
        .rd_data_i (rd_data),
        .wdata_i   (host_wdata),
        .push_i    (push),
        .fill_i    (fill),
        .word_i    (head_word),
        .cfg_o     (cfg),
        .cnt_o     (cnt),
        .rem_o     (rem),
        .busy_o    (busy),
        .udf_o     (udf),
        .last_o    (last_word),
        .pop_o     (pop),
        .flush_o   (flush)
    );

    prf_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WB    (WB)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .byte_i  (nand_byte),
        .pop_i   (pop),
        .word_o  (head_word),
        .fill_o  (fill)
    );

    // Fetch only while at least one word of room remains
    assign nand_req = busy && (rem != '0) && ((FW'(FIFO_DEPTH) - fill) >= FW'(WB));
    assign push     = nand_req && nand_ack;
    assign nand_cs  = cfg.csel;
    assign thr_hit  = busy && (fill >= FW'(cfg.thr));

    always_comb begin
        stat_word               = '0;
        stat_word[CNT_W-1:0]    = rem;
        stat_word[24 +: FW]     = fill;
        stat_word[31]           = udf;
    end

    always_comb begin
        unique case (host_addr)
            ADR_CFG:  host_rdata = cfg;
            ADR_CNT:  host_rdata = 32'(cnt);
            ADR_CTRL: host_rdata = {31'b0, busy};
            ADR_STAT: host_rdata = stat_word;
            ADR_DATA: host_rdata = (fill >= FW'(WB)) ? head_word : last_word;
            default:  host_rdata = '0;
        endcase
    end

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        nand_req |-> (busy && (rem != '0))) else $error("request while idle"); // R4

    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (rem == '0) && (fill == '0) && !host_wr) |=> !busy) else $error("busy stuck"); // R10

endmodule

// File: tb/sim_prf_engine.sv
module sim_prf_engine;
    import prf_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        nand_req, nand_ack = 1'b0, thr_hit;
    logic [7:0]  nand_byte = '0;
    logic [2:0]  nand_cs;

    int n_chk = 0, n_fail = 0;
    logic       ack_en = 1'b0, ack_mode = 1'b0, nidx_clr = 1'b0;
    logic [7:0] seed = '0, nidx = '0;
    int         cyc = 0;

    always #4 clk = ~clk;

    prf_engine u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .nand_req(nand_req), .nand_ack(nand_ack), .nand_byte(nand_byte),
        .nand_cs(nand_cs), .thr_hit(thr_hit)
    );

    // Flash port model: byte k of a stream is seed + k
    always @(negedge clk) begin
        cyc++;
        nand_ack  <= ack_en && (!ack_mode || cyc[0]);
        nand_byte <= seed + nidx;
    end
    always @(posedge clk) begin
        if (nidx_clr) nidx <= '0;
        else if (nand_req && nand_ack) nidx <= nidx + 8'd1;
    end

    // count[31:18] seed[17:10] thr[9:3] ack_mode[2]
    localparam logic [31:0] VEC [4] = '{
        {14'd8,   8'h10, 7'd4,  1'b0, 2'b0},
        {14'd64,  8'hA0, 7'd64, 1'b0, 2'b0},
        {14'd200, 8'h33, 7'd32, 1'b1, 2'b0},
        {14'd4,   8'hFE, 7'd0,  1'b0, 2'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #2 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(input logic [2:0] cs, input logic [6:0] thr, input logic en);
        return {5'b0, cs, 9'b0, thr, en, 6'b0, 1'b0};
    endfunction

    function automatic logic [31:0] expw(input logic [7:0] s, input int w);
        logic [7:0] b0;
        b0 = s + 8'(4 * w);
        return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
    endfunction

    task automatic new_stream(input logic [7:0] s);
        ack_en = 1'b0;
        seed = s;
        @(negedge clk); nidx_clr = 1'b1;
        @(negedge clk); nidx_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL timeout (all requirements) act=running exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(ADR_CFG, d);  chk("R1 cfg", d, 32'h0);
        bus_read(ADR_CTRL, d); chk("R1 ctrl", d, 32'h0);
        bus_read(ADR_STAT, d); chk("R1 status", d, 32'h0);
        @(negedge clk); chk("R1 req/thr", {nand_req, thr_hit}, 2'b00);

        // R5 pause at 61 bytes, threshold 64 stored (R2), chip select (R2)
        new_stream(8'h40);
        bus_write(ADR_CNT, 32'd100);
        bus_write(ADR_CFG, cfgw(3'd5, 7'd64, 1'b1));
        bus_write(ADR_CTRL, 32'd1);
        ack_en = 1'b1; ack_mode = 1'b0;
        repeat (150) @(negedge clk);
        bus_read(ADR_STAT, d); chk("R5 R8 paused status", d, {1'b0, 7'd61, 10'b0, 14'd39});
        @(negedge clk);
        chk("R5 req low when tight", nand_req, 1'b0);
        chk("R12 thr_hit below 64", thr_hit, 1'b0);
        chk("R2 chip select", nand_cs, 3'd5);
        bus_read(ADR_CFG, d); chk("R2 thr 64 kept", d, cfgw(3'd5, 7'd64, 1'b1));

        // R3 start refused while busy
        bus_write(ADR_CNT, 32'd8);
        bus_write(ADR_CTRL, 32'd1);
        bus_read(ADR_STAT, d); chk("R3 remaining unchanged", 32'(d[13:0]), 32'd39);
        bus_read(ADR_CTRL, d); chk("R3 still busy", d, 32'd1);

        // R12 lower threshold while busy
        bus_write(ADR_CFG, cfgw(3'd5, 7'd60, 1'b1));
        @(negedge clk); chk("R12 thr_hit at 61>=60", thr_hit, 1'b1);

        bus_read(ADR_DATA, d); chk("R6 first word", d, expw(8'h40, 0));

        // R11 stop
        bus_write(ADR_CTRL, 32'd0);
        bus_read(ADR_CTRL, d); chk("R11 ctrl idle", d, 32'd0);
        bus_read(ADR_CFG, d);  chk("R11 cfg cleared", d, 32'd0);
        bus_read(ADR_STAT, d); chk("R11 status cleared", d, 32'd0);
        @(negedge clk); chk("R11 req/thr low", {nand_req, thr_hit}, 2'b00);

        // R9 underflow
        bus_read(ADR_DATA, d); chk("R9 last word", d, expw(8'h40, 0));
        bus_read(ADR_STAT, d); chk("R9 flag set", d, 32'h8000_0000);
        bus_read(ADR_STAT, d); chk("R9 flag sticky", d, 32'h8000_0000);

        // R2 threshold above 64 rejected
        bus_write(ADR_CFG, cfgw(3'd2, 7'd65, 1'b1));
        bus_read(ADR_CFG, d); chk("R2 thr 65 rejected", d, 32'd0);

        // R3 start refused with enable clear
        bus_write(ADR_CNT, 32'd8);
        bus_write(ADR_CTRL, 32'd1);
        bus_read(ADR_CTRL, d); chk("R3 no start when disabled", d, 32'd0);

        // R9 flag cleared by accepted start
        new_stream(8'h00);
        bus_write(ADR_CFG, cfgw(3'd0, 7'd0, 1'b1));
        bus_write(ADR_CNT, 32'd4);
        bus_write(ADR_CTRL, 32'd1);
        bus_read(ADR_STAT, d); chk("R9 R3 start clears flag", d, 32'd4);
        bus_write(ADR_CTRL, 32'd0);

        // Table-driven streams: R4 R6 R7 R10
        for (int v = 0; v < 4; v++) begin
            int cnt_v, words;
            logic [7:0] sd;
            cnt_v = int'(VEC[v][31:18]);
            sd    = VEC[v][17:10];
            words = cnt_v / 4;
            new_stream(sd);
            bus_write(ADR_CNT, 32'(cnt_v));
            bus_write(ADR_CFG, cfgw(3'(v), VEC[v][9:3], 1'b1));
            bus_write(ADR_CTRL, 32'd1);
            ack_en = 1'b1; ack_mode = VEC[v][2];
            for (int w = 0; w < words; w++) begin
                for (int t = 0; t < 1000; t++) begin
                    bus_read(ADR_STAT, d);
                    if (d[30:24] >= 7'd4) break;
                end
                bus_read(ADR_DATA, d);
                chk($sformatf("R6 R7 R4 vec%0d word%0d", v, w), d, expw(sd, w));
            end
            bus_read(ADR_CTRL, d); chk($sformatf("R10 vec%0d auto idle", v), d, 32'd0);
            bus_read(ADR_STAT, d); chk($sformatf("R4 R7 vec%0d final status", v), d, 32'd0);
            bus_write(ADR_CTRL, 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule